// File: doc/BRIEF.md
# Switching Fault Supervisor with Current-Limit Hiccup

This block sits beside a step-down converter's PWM engine. Once per switching cycle it decides whether switching may continue, and it drives the PWM enable. It watches three hazards: repeated peak-current-limit events, excessive junction temperature and low input supply. Each hazard has its own fault flag. The current-limit case does not latch. A run of limited cycles causes a fixed blanking window of whole switching cycles, and switching then resumes by itself. The thermal and supply faults each use two thresholds, so a reading that hovers near one threshold cannot make the converter chatter.

The PWM engine pulses a one-clock strobe at the start of each switching cycle. On the same clock it presents the comparator flag for the cycle that has just ended. Temperature arrives as an unsigned code in degrees Celsius and the supply as an unsigned code in millivolts. Both are already sampled into the clock domain. A separate output tells the soft-start logic that the start-up interval has passed without interruption. The interval is set in microseconds and converted to clocks from the clock frequency parameter. No fault ever needs host action to clear.

Top module: `swfault_supervisor`

## Requirements
- R1: `sw_en` is 1 only while `en_in` is 1 and `flt_hiccup`, `flt_thermal` and `flt_uvlo` are all 0. It follows those signals in the same cycle.
- R2: `ilim_hit` is sampled only on clocks where `cyc_start` is 1. The fourth consecutive sampled 1 raises `flt_hiccup` on the next clock edge.
- R3: A `cyc_start` strobe with `ilim_hit` at 0 returns the consecutive-limit count to zero. Three hits, a miss and then three more hits do not raise `flt_hiccup`.
- R4: Once raised, `flt_hiccup` stays at 1 for the next 7 strobes whatever `ilim_hit` shows. It clears at the 8th strobe after the entry strobe.
- R5: When blanking ends, the consecutive-limit count starts again from zero, so four fresh hits are needed to re-enter.
- R6: `flt_thermal` is 0 after reset. It sets when `tj_code` >= 140, clears when `tj_code` <= 125, and holds its value in between. It updates on every clock.
- R7: `flt_uvlo` is 1 after reset. It sets when `vin_mv` <= 2000, clears when `vin_mv` >= 2700, and holds its value in between. It updates on every clock.
- R8: `en_in` at 0 clears `flt_hiccup` and the consecutive-limit count on the next clock edge.
- R9: `reg_ok` rises after SS_US microseconds of clocks with `en_in` at 1 and both `flt_thermal` and `flt_uvlo` at 0. Any clock without that condition restarts the interval and drops `reg_ok` on the next edge.
- R10: While `rst_n` is 0, the outputs are `sw_en`=0, `flt_hiccup`=0, `flt_thermal`=0, `flt_uvlo`=1 and `reg_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Converter enable request |
| cyc_start | input | 1 | One-clock strobe at each switching-cycle start |
| ilim_hit | input | 1 | Peak current limit seen in the cycle just ended |
| tj_code | input | TJ_W (8) | Junction temperature, unsigned °C |
| vin_mv | input | VIN_W (13) | Input supply, unsigned mV |
| sw_en | output | 1 | Permission for the PWM engine to switch |
| flt_hiccup | output | 1 | Current-limit blanking active |
| flt_thermal | output | 1 | Over-temperature shutdown active |
| flt_uvlo | output | 1 | Supply lockout active |
| reg_ok | output | 1 | Soft-start interval complete |

## Verification
The hardest states to reach from the ports are the boundaries of the hiccup counter. Examples are an almost-complete run broken by a single clean cycle, hits that arrive while blanking is in progress, and the eighth strobe that ends blanking. The stimulus drives exact strobe sequences and checks the fault after every strobe. It then proves that the count restarted, by showing that three fresh hits stay silent and the fourth one trips. The hysteresis bands are walked with a table whose readings land exactly on each threshold and one step inside it, from both directions.

// File: rtl/swf_pkg.sv
package swf_pkg;

   // Fault vector carried between the submodules and the top.
   typedef struct packed {
      logic hiccup;
      logic thermal;
      logic uvlo;
   } swf_flt_t;

   // True when no fault forbids switching.
   function automatic logic swf_all_clear(input swf_flt_t f);
      return !(f.hiccup || f.thermal || f.uvlo);
   endfunction

   // True when a fault that stops the power stage outright is present.
   function automatic logic swf_hard_stop(input swf_flt_t f);
      return f.thermal || f.uvlo;
   endfunction

endpackage

// File: rtl/swf_hyst_cmp.sv
// Two-threshold comparator with a registered flag.
// HIGH_SET=1: flag sets at or above SET_LVL and clears at or below CLR_LVL.
// HIGH_SET=0: flag sets at or below SET_LVL and clears at or above CLR_LVL.
module swf_hyst_cmp #(
   parameter int W        = 8,
   parameter int SET_LVL  = 140,
   parameter int CLR_LVL  = 125,
   parameter bit HIGH_SET = 1'b1,
   parameter bit RST_VAL  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] val,
   output logic         flag_o
);

   localparam logic [W-1:0] SET_V = W'(SET_LVL);
   localparam logic [W-1:0] CLR_V = W'(CLR_LVL);

   if (SET_LVL >= (1 << W) || CLR_LVL >= (1 << W)) begin : g_bad_range
      $error("swf_hyst_cmp: threshold does not fit in W bits");
   end

   logic set_c;
   logic clr_c;
   logic flag_q;

   if (HIGH_SET) begin : g_high
      if (CLR_LVL >= SET_LVL) begin : g_bad_band
         $error("swf_hyst_cmp: release level must be below trip level");
      end
      assign set_c = (val >= SET_V);
      assign clr_c = (val <= CLR_V);
   end else begin : g_low
      if (CLR_LVL <= SET_LVL) begin : g_bad_band
         $error("swf_hyst_cmp: release level must be above trip level");
      end
      assign set_c = (val <= SET_V);
      assign clr_c = (val >= CLR_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= RST_VAL;
      end else if (flag_q) begin
         if (clr_c) flag_q <= 1'b0;
      end else if (set_c) begin
         flag_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/swf_hiccup.sv
// Counts consecutive current-limited cycles and blanks switching for a
// fixed number of cycles once the run length is reached.
module swf_hiccup #(
   parameter int RUN_LEN   = 4,
   parameter int BLANK_LEN = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic strobe,
   input  logic hit,
   output logic blank_o
);

   localparam int RW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
   localparam int BW = $clog2(BLANK_LEN + 1);
   localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
   localparam logic [BW-1:0] BLANK_V  = BW'(BLANK_LEN);

   if (RUN_LEN < 1) begin : g_bad_run
      $error("swf_hiccup: RUN_LEN must be at least 1");
   end
   if (BLANK_LEN < 1) begin : g_bad_blank
      $error("swf_hiccup: BLANK_LEN must be at least 1");
   end

   logic [RW-1:0] run_q;
   logic [BW-1:0] left_q;
   logic          blank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         left_q  <= '0;
         blank_q <= 1'b0;
      end else if (clr) begin
         run_q   <= '0;
         left_q  <= '0;
         blank_q <= 1'b0;
      end else if (strobe) begin
         if (blank_q) begin
            // Flag reports a blanked cycle here: ignore it.
            if (left_q == '0) begin
               blank_q <= 1'b0;
            end else begin
               left_q <= left_q - BW'(1);
            end
         end else if (hit) begin
            if (run_q == RUN_LAST) begin
               blank_q <= 1'b1;
               left_q  <= BLANK_V;
               run_q   <= '0;
            end else begin
               run_q <= run_q + RW'(1);
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   assign blank_o = blank_q;

endmodule

// File: rtl/swf_softstart.sv
// Clock counter that flags the end of an uninterrupted start-up interval.
module swf_softstart #(
   parameter int CNT_MAX = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done_o
);

   localparam int CW = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] LAST = CW'(CNT_MAX);

   if (CNT_MAX < 1) begin : g_bad_cnt
      $error("swf_softstart: CNT_MAX must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign done_o = (cnt_q == LAST);

endmodule

// File: rtl/swfault_supervisor.sv
module swfault_supervisor #(
   parameter int TJ_W       = 8,
   parameter int VIN_W      = 13,
   parameter int TJ_TRIP    = 140,
   parameter int TJ_RELEASE = 125,
   parameter int VIN_ON     = 2700,
   parameter int VIN_OFF    = 2000,
   parameter int ILIM_RUN   = 4,
   parameter int ILIM_BLANK = 7,
   parameter int CLK_KHZ    = 125000,
   parameter int SS_US      = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_in,
   input  logic             cyc_start,
   input  logic             ilim_hit,
   input  logic [TJ_W-1:0]  tj_code,
   input  logic [VIN_W-1:0] vin_mv,
   output logic             sw_en,
   output logic             flt_hiccup,
   output logic             flt_thermal,
   output logic             flt_uvlo,
   output logic             reg_ok
);
   import swf_pkg::*;

   localparam int SS_CYC = (CLK_KHZ / 1000) * SS_US;

   if (SS_CYC < 1) begin : g_bad_ss
      $error("swfault_supervisor: soft-start interval below one clock");
   end

   swf_flt_t flt;
   logic     ss_run;

   swf_hiccup #(
      .RUN_LEN   (ILIM_RUN),
      .BLANK_LEN (ILIM_BLANK)
   ) u_hiccup (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!en_in),
      .strobe  (cyc_start),
      .hit     (ilim_hit),
      .blank_o (flt.hiccup)
   );

   swf_hyst_cmp #(
      .W        (TJ_W),
      .SET_LVL  (TJ_TRIP),
      .CLR_LVL  (TJ_RELEASE),
      .HIGH_SET (1'b1),
      .RST_VAL  (1'b0)
   ) u_thermal (
      .clk    (clk),
      .rst_n  (rst_n),
      .val    (tj_code),
      .flag_o (flt.thermal)
   );

   swf_hyst_cmp #(
      .W        (VIN_W),
      .SET_LVL  (VIN_OFF),
      .CLR_LVL  (VIN_ON),
      .HIGH_SET (1'b0),
      .RST_VAL  (1'b1)
   ) u_uvlo (
      .clk    (clk),
      .rst_n  (rst_n),
      .val    (vin_mv),
      .flag_o (flt.uvlo)
   );

   assign ss_run = en_in && !swf_hard_stop(flt);

   swf_softstart #(
      .CNT_MAX (SS_CYC)
   ) u_ss (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ss_run),
      .done_o (reg_ok)
   );

   assign sw_en       = en_in && swf_all_clear(flt);
   assign flt_hiccup  = flt.hiccup;
   assign flt_thermal = flt.thermal;
   assign flt_uvlo    = flt.uvlo;

endmodule

// File: rtl/swfault_supervisor_chk.sv
module swfault_supervisor_chk #(
   parameter int TJ_W       = 8,
   parameter int VIN_W      = 13,
   parameter int TJ_TRIP    = 140,
   parameter int TJ_RELEASE = 125,
   parameter int VIN_ON     = 2700,
   parameter int VIN_OFF    = 2000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_in,
   input logic             cyc_start,
   input logic             ilim_hit,
   input logic [TJ_W-1:0]  tj_code,
   input logic [VIN_W-1:0] vin_mv,
   input logic             sw_en,
   input logic             flt_hiccup,
   input logic             flt_thermal,
   input logic             flt_uvlo,
   input logic             reg_ok
);

   a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_in || flt_hiccup || flt_thermal || flt_uvlo) |-> !sw_en);

   a_r2_hiccup_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_hiccup) |-> $past(cyc_start && ilim_hit && en_in));

   a_r4_hiccup_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_hiccup) |-> $past(cyc_start || !en_in));

   a_r6_therm_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (tj_code >= TJ_W'(TJ_TRIP)) |=> flt_thermal);

   a_r6_therm_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_thermal && tj_code > TJ_W'(TJ_RELEASE)) |=> flt_thermal);

   a_r7_uvlo_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (vin_mv <= VIN_W'(VIN_OFF)) |=> flt_uvlo);

   a_r7_uvlo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_uvlo && vin_mv < VIN_W'(VIN_ON)) |=> flt_uvlo);

   a_r8_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en_in |=> !flt_hiccup);

   a_r9_ss_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_ok) |-> $past(!en_in || flt_thermal || flt_uvlo));

endmodule

bind swfault_supervisor swfault_supervisor_chk #(
   .TJ_W       (TJ_W),
   .VIN_W      (VIN_W),
   .TJ_TRIP    (TJ_TRIP),
   .TJ_RELEASE (TJ_RELEASE),
   .VIN_ON     (VIN_ON),
   .VIN_OFF    (VIN_OFF)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_in       (en_in),
   .cyc_start   (cyc_start),
   .ilim_hit    (ilim_hit),
   .tj_code     (tj_code),
   .vin_mv      (vin_mv),
   .sw_en       (sw_en),
   .flt_hiccup  (flt_hiccup),
   .flt_thermal (flt_thermal),
   .flt_uvlo    (flt_uvlo),
   .reg_ok      (reg_ok)
);

// File: tb/swfault_supervisor_tb_top.sv
`timescale 1ns/1ps
module swfault_supervisor_tb_top;

   localparam int SS_US   = 1;
   localparam int SS_CYC  = 125;   // 125 MHz clock, 1 us
   localparam int WDOG    = 100000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        en_in;
   logic        cyc_start;
   logic        ilim_hit;
   logic [7:0]  tj_code;
   logic [12:0] vin_mv;
   logic        sw_en, flt_hiccup, flt_thermal, flt_uvlo, reg_ok;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   swfault_supervisor #(.SS_US(SS_US)) dut_i (
      .clk (clk), .rst_n (rst_n), .en_in (en_in), .cyc_start (cyc_start),
      .ilim_hit (ilim_hit), .tj_code (tj_code), .vin_mv (vin_mv),
      .sw_en (sw_en), .flt_hiccup (flt_hiccup), .flt_thermal (flt_thermal),
      .flt_uvlo (flt_uvlo), .reg_ok (reg_ok)
   );

   // {tj_code, vin_mv, expected thermal, expected uvlo}
   localparam logic [22:0] VEC [0:11] = '{
      {8'd25,  13'd3600, 1'b0, 1'b0},
      {8'd139, 13'd2001, 1'b0, 1'b0},
      {8'd140, 13'd2000, 1'b1, 1'b1},
      {8'd126, 13'd2699, 1'b1, 1'b1},
      {8'd125, 13'd2700, 1'b0, 1'b0},
      {8'd139, 13'd2100, 1'b0, 1'b0},
      {8'd200, 13'd500,  1'b1, 1'b1},
      {8'd130, 13'd2500, 1'b1, 1'b1},
      {8'd0,   13'd5500, 1'b0, 1'b0},
      {8'd255, 13'd8191, 1'b1, 1'b0},
      {8'd125, 13'd0,    1'b0, 1'b1},
      {8'd25,  13'd3600, 1'b0, 1'b0}
   };

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic strobe(input logic h);
      cyc_start = 1'b1;
      ilim_hit  = h;
      tick();
      cyc_start = 1'b0;
      ilim_hit  = 1'b0;
      tick();
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; en_in = 1'b0; cyc_start = 1'b0; ilim_hit = 1'b0;
      tj_code = 8'd25; vin_mv = 13'd0;
      tick(); tick();
      // R10: reset values
      chk("R10 sw_en", sw_en, 1'b0);
      chk("R10 hiccup", flt_hiccup, 1'b0);
      chk("R10 thermal", flt_thermal, 1'b0);
      chk("R10 uvlo", flt_uvlo, 1'b1);
      chk("R10 reg_ok", reg_ok, 1'b0);
      rst_n = 1'b1;
      en_in = 1'b1;

      // R6 / R7 / R1: hysteresis table walk
      for (int i = 0; i < 12; i++) begin
         tj_code = VEC[i][22:15];
         vin_mv  = VEC[i][14:2];
         tick();
         chk("R6 thermal", flt_thermal, VEC[i][1]);
         chk("R7 uvlo", flt_uvlo, VEC[i][0]);
         chk("R1 sw_en vs faults", sw_en, !(VEC[i][1] || VEC[i][0]));
      end

      // R9: soft-start interval
      en_in = 1'b0;
      tick(); tick();
      chk("R1 sw_en with en low", sw_en, 1'b0);
      en_in = 1'b1;
      for (int i = 0; i < SS_CYC - 1; i++) tick();
      chk("R9 reg_ok before interval", reg_ok, 1'b0);
      tick();
      chk("R9 reg_ok at interval", reg_ok, 1'b1);
      tj_code = 8'd150;
      tick(); tick();
      chk("R9 reg_ok dropped by thermal", reg_ok, 1'b0);
      tj_code = 8'd25;
      tick(); tick();

      // R3: broken run does not trip
      strobe(1'b1); strobe(1'b1); strobe(1'b1);
      strobe(1'b0);
      strobe(1'b1); strobe(1'b1); strobe(1'b1);
      chk("R3 no hiccup after broken run", flt_hiccup, 1'b0);
      chk("R1 sw_en while clear", sw_en, 1'b1);
      // R2: fourth consecutive hit trips
      strobe(1'b1);
      chk("R2 hiccup after 4 hits", flt_hiccup, 1'b1);
      chk("R1 sw_en during hiccup", sw_en, 1'b0);

      // R4: seven blanked cycles, hits ignored
      for (int i = 0; i < 7; i++) begin
         strobe(1'b1);
         chk("R4 hiccup held", flt_hiccup, 1'b1);
      end
      strobe(1'b1);
      chk("R4 hiccup cleared at 8th strobe", flt_hiccup, 1'b0);

      // R5: count restarts from zero
      strobe(1'b1); strobe(1'b1); strobe(1'b1);
      chk("R5 three fresh hits silent", flt_hiccup, 1'b0);
      strobe(1'b1);
      chk("R5 fourth fresh hit trips", flt_hiccup, 1'b1);

      // R8: enable low clears hiccup and count
      en_in = 1'b0;
      tick();
      chk("R8 hiccup cleared by enable", flt_hiccup, 1'b0);
      en_in = 1'b1;
      strobe(1'b1); strobe(1'b1);
      en_in = 1'b0;
      tick();
      en_in = 1'b1;
      strobe(1'b1); strobe(1'b1);
      chk("R8 count cleared by enable", flt_hiccup, 1'b0);
      strobe(1'b1); strobe(1'b1);
      chk("R2 trip after full run", flt_hiccup, 1'b1);

      finish_run();
   end

   initial begin
      for (int i = 0; i < WDOG; i++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule